// File: doc/BRIEF.md
# Caption Line Encoder

This block produces the digital luma waveform for the two caption characters carried on one video line of each field. The timing generator feeds it a strobe at the start of each line (the leading edge of horizontal sync), the current line number and a flag for the second field. When that line is the caption line of an enabled field, the block emits one 8-bit level code per 13.5 MHz sample. The line holds a quiet gap, a sine-shaped clock run-in, three start bits and then sixteen NRZ data bits. On every other line the block drives the blanking code.

A host writes two 7-bit characters per field into holding registers. The block computes each character's odd-parity bit itself. It takes the characters at the start of the caption line and clears the holding register at that point. If the host does not refresh the data, the next caption line carries null characters. A per-field status bit goes low on each write and goes high once the bytes have been fully sent.

Bit timing follows a grid of exactly 1/32 of the line period, split into quarter-bit steps. A fractional phase accumulator places the sample grid on that bit grid, because the line length in samples is not a multiple of 32.

Top module: `cc_line_encoder`

## Requirements
- R1: Encoding happens only on a line whose start strobe sees line number 21 with field_two=0 and en_f1=1 (field one), or line 284 with field_two=1 and en_f2=1 (field two). Every other line outputs code 0 for all samples.
- R2: Sample n of a line (n=0 in the cycle after the strobe edge) lies in quarter-bit slot q=floor(128*n/SPL), with phase a=(128*n) mod SPL. Its level code appears on `lvl` after the edge that is n+1 clocks after the edge that sampled `line_start`.
- R3: For q in 21..46 (run-in, 6.5 bit periods), the code is (T*LVL_HI)>>8. Here T=round(128*(1-cos(2*pi*i/16))) and i=4*((q-21) mod 4)+floor(4*a/SPL). This gives a sine between 0 and 50 IRE, centred on 25 IRE.
- R4: Samples with q<21 (the gap after sync) or q>=123 output code 0 (blanking, 0 IRE), and the code never exceeds LVL_HI.
- R5: Slots q in 47..58 carry the start bits 0, 0, 1, each 4 slots long. A one is code LVL_HI (50 IRE) and a zero is code 0.
- R6: Slots q in 59..122 carry 16 data bits, each 4 slots long, least significant bit first. Bit k=(q-59)/4 is taken from the word {parity2, char2[6:0], parity1, char1[6:0]}.
- R7: Each parity bit (word bits 7 and 15) is 1 exactly when its 7-bit character has an even number of ones, so that every byte has odd parity.
- R8: A write (wr_en=1) stores wr_data[6:0] as the first character and wr_data[13:7] as the second character of the field that wr_fld selects (0 = field one, 1 = field two). The write also clears that field's status bit in the next cycle.
- R9: When a field's caption line starts, its holding register clears to zero. If there is no new write, the next caption line of that field sends null characters (bytes 0x80).
- R10: A field's status bit (status[0] for field one, status[1] for field two) goes high when its data window ends, unless a write to that field came after the line start.
- R11: A caption line whose field is disabled leaves that field's holding register and status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | LNW | Current line number |
| field_two | input | 1 | High during the second field |
| en_f1 | input | 1 | Enables captions on line 21 of field one |
| en_f2 | input | 1 | Enables captions on line 284 of field two |
| wr_en | input | 1 | Write strobe for a holding register |
| wr_fld | input | 1 | Field selected by the write |
| wr_data | input | 14 | Two 7-bit characters, first in bits 6:0 |
| status | output | 2 | Per-field sent flag |
| lvl | output | 8 | Luma level code per sample |

## Verification
The hardest case to reach is a host write that arrives in the middle of a caption line, after the holding register has been taken and cleared but before the data window ends. That write must keep the status low and survive until the next caption line. The bench brings this about by raising the write strobe at a chosen sample count inside the line. Other lines place writes before a line starts, or pass over a caption line while its field is disabled. Every sample of each line is compared with the value computed from the grid formula. This covers the fractional steps where a slot boundary falls between two samples.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {SEG_BLANK, SEG_RUNIN, SEG_START, SEG_DATA} cc_seg_e;

  // 7-bit character to transmitted byte with odd parity in the MSB
  function automatic logic [7:0] cc_char(input logic [6:0] c);
    return {~^c, c};
  endfunction

  // raised-cosine run-in table, 0..256, folded about index 8
  function automatic logic [8:0] cc_sine(input logic [3:0] idx);
    logic [3:0] k;
    k = idx[3] ? 4'(5'd16 - {1'b0, idx}) : idx;
    case (k)
      4'd0:    return 9'd0;
      4'd1:    return 9'd10;
      4'd2:    return 9'd37;
      4'd3:    return 9'd79;
      4'd4:    return 9'd128;
      4'd5:    return 9'd177;
      4'd6:    return 9'd219;
      4'd7:    return 9'd246;
      default: return 9'd256;
    endcase
  endfunction

  // floor(4*acc/spl) for acc < spl, by comparison
  function automatic logic [1:0] cc_sub(input int unsigned acc, input int unsigned spl);
    logic [1:0] s;
    s = 2'd0;
    if (4 * acc >= spl)     s = s + 2'd1;
    if (4 * acc >= 2 * spl) s = s + 2'd1;
    if (4 * acc >= 3 * spl) s = s + 2'd1;
    return s;
  endfunction

endpackage

// File: rtl/cc_phase.sv
module cc_phase #(
  parameter int SPL = 858,
  parameter int AW  = 10,
  parameter int QW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  output logic [AW-1:0] acc,
  output logic [QW-1:0] q,
  output logic          qstep
);
  localparam int STEP = 128;            // quarter-bit slots per line
  localparam int QMAX = STEP;
  localparam logic [AW:0] STEP_W = (AW+1)'(STEP);
  localparam logic [AW:0] SPL_W  = (AW+1)'(SPL);

  logic [AW:0] sum;
  logic        wrap, run;

  always_comb begin
    sum  = {1'b0, acc} + STEP_W;
    wrap = (sum >= SPL_W);
    run  = (q < QW'(QMAX));
  end

  assign qstep = run && wrap && !line_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      q   <= QW'(QMAX);
    end else if (line_start) begin
      acc <= '0;
      q   <= '0;
    end else if (run) begin
      if (wrap) begin
        acc <= AW'(sum - SPL_W);
        q   <= q + 1'b1;
      end else begin
        acc <= sum[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/cc_store.sv
module cc_store (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_fld,
  input  logic [13:0]     wr_data,
  input  logic [1:0]      cap,
  input  logic [1:0]      done,
  output logic [1:0][13:0] hold,
  output logic [1:0]      status
);
  logic [1:0] dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      status <= '0;
      dirty  <= '0;
    end else begin
      for (int f = 0; f < 2; f++) begin
        if (wr_en && (wr_fld == f[0])) begin
          hold[f]   <= wr_data;
          status[f] <= 1'b0;
          dirty[f]  <= 1'b1;
        end else begin
          if (cap[f]) begin
            hold[f]  <= '0;
            dirty[f] <= 1'b0;
          end
          if (done[f] && !dirty[f]) status[f] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cc_shaper.sv
module cc_shaper #(
  parameter int SPL     = 858,
  parameter int AW      = 10,
  parameter int QW      = 8,
  parameter int LVL_HI  = 100,
  parameter int Q_RUN   = 21,
  parameter int Q_START = 47,
  parameter int Q_DATA  = 59,
  parameter int Q_END   = 123
) (
  input  logic          act,
  input  logic [AW-1:0] acc,
  input  logic [QW-1:0] q,
  input  logic [15:0]   word,
  output logic [7:0]    code
);
  import cc_pkg::*;

  localparam logic [7:0] HI = 8'(LVL_HI);

  cc_seg_e     seg;
  logic [QW-1:0] rel_run, rel_sb, rel_dat;
  logic [3:0]  idx;
  logic [16:0] prod;

  always_comb begin
    if (!act || q < QW'(Q_RUN) || q >= QW'(Q_END)) seg = SEG_BLANK;
    else if (q < QW'(Q_START))                     seg = SEG_RUNIN;
    else if (q < QW'(Q_DATA))                      seg = SEG_START;
    else                                           seg = SEG_DATA;

    rel_run = q - QW'(Q_RUN);
    rel_sb  = q - QW'(Q_START);
    rel_dat = q - QW'(Q_DATA);
    idx     = {rel_run[1:0], cc_sub(int'(acc), SPL)};
    prod    = 17'(cc_sine(idx)) * 17'(LVL_HI);

    case (seg)
      SEG_RUNIN: code = prod[15:8];
      SEG_START: code = (rel_sb[3:2] == 2'd2) ? HI : 8'd0;
      SEG_DATA:  code = word[rel_dat[5:2]] ? HI : 8'd0;
      default:   code = 8'd0;
    endcase
  end
endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder #(
  parameter int SPL     = 858,
  parameter int LVL_HI  = 100,
  parameter int LNW     = 10,
  parameter int LINE_F1 = 21,
  parameter int LINE_F2 = 284,
  parameter int GAP_Q   = 21
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           line_start,
  input  logic [LNW-1:0] line_num,
  input  logic           field_two,
  input  logic           en_f1,
  input  logic           en_f2,
  input  logic           wr_en,
  input  logic           wr_fld,
  input  logic [13:0]    wr_data,
  output logic [1:0]     status,
  output logic [7:0]     lvl
);
  import cc_pkg::*;

  localparam int AW      = $clog2(SPL);
  localparam int QW      = 8;
  localparam int Q_START = GAP_Q + 26;   // run-in of 6.5 bit periods
  localparam int Q_DATA  = Q_START + 12; // three start bits
  localparam int Q_END   = Q_DATA + 64;  // sixteen data bits

  logic [AW-1:0]     acc;
  logic [QW-1:0]     q;
  logic              qstep;
  logic              m1, m2, fin;
  logic [1:0]        cap, done;
  logic              act_r, fsel_r;
  logic [15:0]       word_r;
  logic [1:0][13:0]  hold;
  logic [13:0]       hold_f1, hold_f2;
  logic [7:0]        lvl_nx;

  assign m1 = en_f1 && !field_two && (line_num == LNW'(LINE_F1));
  assign m2 = en_f2 &&  field_two && (line_num == LNW'(LINE_F2));
  assign cap = {line_start & m2, line_start & m1};

  assign fin  = act_r && qstep && (q == QW'(Q_END - 1));
  assign done = {fin & fsel_r, fin & ~fsel_r};

  assign hold_f1 = hold[0];
  assign hold_f2 = hold[1];

  cc_phase #(.SPL(SPL), .AW(AW), .QW(QW)) u_phase (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .acc(acc), .q(q), .qstep(qstep)
  );

  cc_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fld(wr_fld),
    .wr_data(wr_data), .cap(cap), .done(done),
    .hold(hold), .status(status)
  );

  cc_shaper #(
    .SPL(SPL), .AW(AW), .QW(QW), .LVL_HI(LVL_HI), .Q_RUN(GAP_Q),
    .Q_START(Q_START), .Q_DATA(Q_DATA), .Q_END(Q_END)
  ) u_shape (
    .act(act_r), .acc(acc), .q(q), .word(word_r), .code(lvl_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_r  <= 1'b0;
      fsel_r <= 1'b0;
      word_r <= '0;
      lvl    <= '0;
    end else begin
      lvl <= lvl_nx;
      if (line_start) begin
        act_r  <= m1 | m2;
        fsel_r <= m2;
        if (m2) word_r <= {cc_char(hold_f2[13:7]), cc_char(hold_f2[6:0])};
        else    word_r <= {cc_char(hold_f1[13:7]), cc_char(hold_f1[6:0])};
      end
    end
  end
endmodule

// File: rtl/cc_line_chk.sv
module cc_line_chk #(
  parameter int LVL_HI = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  lvl,
  input logic        act,
  input logic [7:0]  q,
  input logic [1:0]  status,
  input logic [1:0]  done,
  input logic [1:0]  cap,
  input logic        wr_en,
  input logic        wr_fld,
  input logic [13:0] hold0,
  input logic [13:0] hold1
);
  // R4
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 8'(LVL_HI));

  // R1
  idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> lvl == 8'd0);

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q <= 8'd128);

  // R8
  wr_clears_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_fld |=> !status[0]);

  // R8
  wr_clears_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_fld |=> !status[1]);

  // R10
  status_src_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(done[0]));

  // R10
  status_src_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(done[1]));

  // R9
  take_clears_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] && !(wr_en && !wr_fld) |=> hold0 == 14'd0);

  // R9
  take_clears_f2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap[1] && !(wr_en && wr_fld) |=> hold1 == 14'd0);
endmodule

bind cc_line_encoder cc_line_chk #(.LVL_HI(LVL_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .lvl(lvl), .act(act_r), .q(q),
  .status(status), .done(done), .cap(cap), .wr_en(wr_en), .wr_fld(wr_fld),
  .hold0(hold_f1), .hold1(hold_f2)
);

// File: tb/sim_cc_line_encoder.sv
`timescale 1ns/1ps
module sim_cc_line_encoder;
  localparam int SPL = 858;
  localparam int HI  = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [9:0]  line_num = '0;
  logic        field_two = 1'b0;
  logic        en_f1 = 1'b0, en_f2 = 1'b0;
  logic        wr_en = 1'b0, wr_fld = 1'b0;
  logic [13:0] wr_data = '0;
  logic [1:0]  status;
  logic [7:0]  lvl;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [13:0] m_hold [2];
  bit          m_stat [2];

  always #2 clk = ~clk;

  cc_line_encoder u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_two(field_two), .en_f1(en_f1), .en_f2(en_f2), .wr_en(wr_en),
    .wr_fld(wr_fld), .wr_data(wr_data), .status(status), .lvl(lvl)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_word(input logic [13:0] h);
    logic [6:0] c1, c2;
    logic p1, p2;
    c1 = h[6:0];
    c2 = h[13:7];
    p1 = ($countones(c1) % 2 == 0);
    p2 = ($countones(c2) % 2 == 0);
    return {p2, c2, p1, c1};
  endfunction

  function automatic int exp_lvl(input int n, input logic [15:0] w, input bit act);
    int qq, a, i, t;
    real ang;
    if (!act) return 0;
    qq = (128 * n) / SPL;
    a  = (128 * n) % SPL;
    if (qq < 21 || qq >= 123) return 0;
    if (qq < 47) begin
      i   = 4 * ((qq - 21) % 4) + (4 * a) / SPL;
      ang = 2.0 * 3.14159265358979 * i / 16.0;
      t   = $rtoi(128.0 * (1.0 - $cos(ang)) + 0.5);
      return (t * HI) / 256;
    end
    if (qq < 59) return (((qq - 47) / 4) == 2) ? HI : 0;
    return w[(qq - 59) / 4] ? HI : 0;
  endfunction

  function automatic string region(input int n, input bit act);
    int qq, k;
    if (!act) return "R1";
    qq = (128 * n) / SPL;
    if (qq < 21 || qq >= 123) return "R2/R4";
    if (qq < 47) return "R2/R3";
    if (qq < 59) return "R2/R5";
    k = (qq - 59) / 4;
    return (k == 7 || k == 15) ? "R2/R7" : "R2/R6";
  endfunction

  task automatic write_fld(input bit f, input logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_fld = f; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_hold[f] = d;
    m_stat[f] = 0;
    check("R8 status cleared by write", int'(status[f]), 0);
  endtask

  // midwr >= 0: write new data to the active field at that sample
  task automatic run_line(input int ln, input bit f2, input int midwr);
    bit act, fi, dirty;
    logic [15:0] w;
    logic [13:0] nd;
    bit s_before [2];
    fi  = f2;
    act = (ln == 21 && !f2 && en_f1) || (ln == 284 && f2 && en_f2);
    s_before[0] = m_stat[0];
    s_before[1] = m_stat[1];
    w = '0;
    dirty = 0;
    if (act) begin
      w = mk_word(m_hold[fi]);
      m_hold[fi] = '0;
    end
    @(negedge clk);
    line_start = 1'b1; line_num = 10'(ln); field_two = f2;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
    for (int n = 0; n < SPL; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (wr_en) wr_en = 1'b0;
      check(region(n, act), int'(lvl), exp_lvl(n, w, act));
      if (act && n == midwr) begin
        nd = 14'($urandom);
        wr_en = 1'b1; wr_fld = fi; wr_data = nd;
        m_hold[fi] = nd;
        m_stat[fi] = 0;
        dirty = 1;
      end
    end
    if (act && !dirty) m_stat[fi] = 1;
    if (act) check("R10 status after line", int'(status[fi]), int'(m_stat[fi]));
    else begin
      check("R11 status f1 unchanged", int'(status[0]), int'(s_before[0]));
      check("R11 status f2 unchanged", int'(status[1]), int'(s_before[1]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_hold[0] = '0; m_hold[1] = '0;
    m_stat[0] = 0;  m_stat[1] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(lvl), 0);
    check("R10 reset status", int'(status), 0);
    rst_n = 1'b1;

    // disabled field: nothing sent, data kept (R1, R11)
    write_fld(0, {7'h41, 7'h00});
    run_line(21, 0, -1);
    // enable field one: run-in, start bits, data with parity (R3, R5, R6, R7)
    en_f1 = 1'b1;
    run_line(21, 0, -1);
    // unrefreshed: nulls (R9)
    run_line(21, 0, -1);
    // wrong field flag on line 21, and a non-caption line (R1)
    write_fld(0, {7'h7F, 7'h55});
    run_line(21, 1, -1);
    run_line(22, 0, -1);
    run_line(21, 0, -1);
    // field two (R1, R6)
    en_f2 = 1'b1;
    write_fld(1, {7'h2A, 7'h01});
    run_line(284, 0, -1);
    run_line(284, 1, -1);
    // write landing mid-line keeps status low and survives (R10)
    write_fld(1, {7'h13, 7'h6E});
    run_line(284, 1, 300);
    run_line(284, 1, -1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int r;
      r = int'($urandom % 6);
      if ($urandom % 3 == 0) en_f1 = 1'($urandom);
      if ($urandom % 3 == 0) en_f2 = 1'($urandom);
      if ($urandom % 2 == 0) write_fld(1'($urandom), 14'($urandom));
      case (r)
        0, 1:    run_line(21, 0, ($urandom % 5 == 0) ? int'($urandom % 700) : -1);
        2, 3:    run_line(284, 1, ($urandom % 5 == 0) ? int'($urandom % 700) : -1);
        4:       run_line(284, 0, -1);
        default: run_line(int'($urandom % 300), 1'($urandom), -1);
      endcase
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule